// File: doc/BRIEF.md
# MDIO Management Master with Command Word

This block is a serial management master for Ethernet PHYs. Software, or any on-chip controller, writes one 32-bit command word. The word holds a start code, an opcode, a PHY port address, a register or device address and a 16-bit data value. Setting the access bit launches one management frame on MDC/MDIO. The fields of the word pass straight into the fields of the frame, so the same engine sends Clause 22 reads and writes and every Clause 45 frame type. No logic in the block knows which clause is in use.

A Clause 45 access takes two commands in sequence. The first is an address frame, which carries the device address in the register field and the register address in the data field. Once the access bit of that frame has cleared, a second command sends the read or write frame to the same device. The access bit reads back as a busy flag until the frame ends. After a read frame, the low half of the word holds the 16 bits that the PHY returned. MDC comes from the system clock through a divider set by a parameter. The MDIO pad is driven through an output-enable signal.

Top module: `mdio_cmd_master`

## Requirements
- R1: Command word layout. Bit 31 is the access/busy bit, bits 29:25 are the register/device address, bits 24:20 are the PHY port, bits 19:18 are the opcode, bits 17:16 are the start code and bits 15:0 are the data. Bit 30 reads 0. After reset the word reads 0. A write while idle with bit 31 clear stores bits 29:0 and starts no frame.
- R2: A write while idle with bit 31 set starts a frame. Bit 31 reads 1 from the cycle after the write until the final falling MDC edge of the frame, then clears by itself. A frame lasts 64 MDC periods, which is 128*HALF_DIV system clocks.
- R3: MDC stays low while idle. While a frame runs, MDC has a period of 2*HALF_DIV system clocks and starts with a low half.
- R4: Each frame carries 64 bits, MSB first, valid at each rising MDC edge, in this order: 32 ones, the 2-bit start code, the 2-bit opcode, the 5-bit port, the 5-bit register/device field, 2 turnaround bits and 16 data bits. The start code is sent as written: 0 gives the Clause 45 pattern 00 and 1 gives the Clause 22 pattern 01.
- R5: Opcode 0 (Clause 45 address) and opcode 1 (write) are driven frames. MDIO is enabled for all 64 bits, the turnaround is 10, and the data bits are bits 15:0 of the word.
- R6: Opcode 2 (Clause 22 read) and opcode 3 (Clause 45 read) are read frames. The output enable is low for the 2 turnaround bits and the 16 data bits. MDIO input is sampled at each rising MDC edge of the data bits. Once busy clears, the 16 sampled bits appear in bits 15:0, MSB first.
- R7: On read frames the data field written with the command has no effect on the bits driven onto MDIO or on the value returned.
- R8: Writes while busy are ignored. The word read back, the frame in progress and the idle state that follows are all unchanged.
- R9: While a frame runs, the MDIO output changes only at a falling MDC edge. This gives half an MDC period of setup before each rising edge.
- R10: A Clause 45 address frame (start 0, opcode 0) carries the device address in the register field and the register address in the data field. The read or write frame that follows carries the same device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word written when cmd_wr is high |
| cmd_rdata | output | 32 | Command word read back: busy bit, fields, read result |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable, high while the master drives the line |
| mdio_i | input | 1 | MDIO value sensed at the pad |

## Verification
The bench looks at the turnaround of read frames. A design that keeps driving through the two turnaround bits would contend with the PHY, and a design that samples one bit early or late would return the read value shifted by one place. A write sent while a frame runs must be refused. A design that accepted it would corrupt the fields read back or start a second frame once the first ends. The bench also checks that busy lasts exactly 64 MDC periods and that MDIO changes only on falling MDC edges. A divider or bit counter that is off by one would lengthen the frame or break the setup margin. A Clause 45 address frame followed by a read shows that the device field and the data field go out unchanged for each opcode.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = FRAME_BITS - DATA_BITS - 2;
  localparam int DATA_POS   = FRAME_BITS - DATA_BITS;
  localparam int ACC_BIT    = 31;

  typedef struct packed {
    logic [4:0]           regad;
    logic [4:0]           port;
    logic [1:0]           op;
    logic [1:0]           st;
    logic [DATA_BITS-1:0] data;
  } mdio_cmd_t;

  function automatic logic op_is_read(logic [1:0] op);
    return op[1];
  endfunction

  function automatic mdio_cmd_t cmd_of_word(logic [31:0] w);
    return mdio_cmd_t'(w[29:0]);
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
    logic [1:0]           ta;
    logic [DATA_BITS-1:0] d;
    ta = op_is_read(c.op) ? 2'b00 : 2'b10;
    d  = op_is_read(c.op) ? '0 : c.data;
    return {{32{1'b1}}, c.st, c.op, c.port, c.regad, ta, d};
  endfunction

  function automatic logic [31:0] pack_status(logic busy, mdio_cmd_t c);
    return {busy, 1'b0, c};
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap    = (cnt == LAST);
  assign rise_ev = run & wrap & ~mdc;
  assign fall_ev = run & wrap & mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  rd_in,
  input  logic                  rise_ev,
  input  logic                  fall_ev,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  done_ev,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [DATA_BITS-1:0]  rd_data
);
  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0]      idx;
  logic                  rd_q;
  logic                  last_bit;
  logic                  in_release;
  logic                  in_data;

  assign last_bit   = (idx == IDX_W'(FRAME_BITS - 1));
  assign in_release = rd_q & (idx >= IDX_W'(TA_POS));
  assign in_data    = rd_q & (idx >= IDX_W'(DATA_POS));
  assign done_ev    = busy & fall_ev & last_bit;
  assign mdio_o     = sh[FRAME_BITS-1];
  assign mdio_oe    = busy & ~in_release;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sh      <= '0;
      idx     <= '0;
      rd_q    <= 1'b0;
      rd_data <= '0;
    end else if (start) begin
      busy <= 1'b1;
      sh   <= frame_in;
      idx  <= '0;
      rd_q <= rd_in;
    end else if (busy) begin
      if (rise_ev && in_data) begin
        rd_data <= {rd_data[DATA_BITS-2:0], mdio_i};
      end
      if (fall_ev) begin
        if (last_bit) begin
          busy <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          sh  <= {sh[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t            cmd_q;
  mdio_cmd_t            cmd_in;
  logic                 busy;
  logic                 accept;
  logic                 start_ev;
  logic                 done_ev;
  logic                 rise_ev;
  logic                 fall_ev;
  logic [DATA_BITS-1:0] rd_data;

  assign cmd_in   = cmd_of_word(cmd_wdata);
  assign accept   = cmd_wr & ~busy;
  assign start_ev = accept & cmd_wdata[ACC_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (accept) begin
      cmd_q <= cmd_in;
    end else if (done_ev && op_is_read(cmd_q.op)) begin
      cmd_q.data <= rd_data;
    end
  end

  assign cmd_rdata = pack_status(busy, cmd_q);

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) div_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .mdc     (mdc),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  mdio_frame_seq seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_ev),
    .frame_in (build_frame(cmd_in)),
    .rd_in    (op_is_read(cmd_in.op)),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .done_ev  (done_ev),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [31:0] cmd_wdata,
  input logic [31:0] cmd_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        rise_ev,
  input logic        fall_ev,
  input logic        done_ev
);
  AST_IDLE_WR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && !cmd_wdata[31]) |=> !busy); // R1
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && cmd_wdata[31]) |=> cmd_rdata[31]); // R2
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !cmd_rdata[31]); // R2
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R3
  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_ev && fall_ev)); // R3
  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R6
  AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && !done_ev) |=> $stable(cmd_rdata)); // R8
  AST_MDIO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_ev) |=> $stable(mdio_o)); // R9
endmodule

bind mdio_cmd_master mdio_cmd_master_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr    (cmd_wr),
  .cmd_wdata (cmd_wdata),
  .cmd_rdata (cmd_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .busy      (busy),
  .rise_ev   (rise_ev),
  .fall_ev   (fall_ev),
  .done_ev   (done_ev)
);

// File: tb/mdio_cmd_master_tb_top.sv
`timescale 1ns/1ps
module mdio_cmd_master_tb_top;
  localparam int HALF = 4;
  localparam int FRAME_CLKS = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int failures = 0;

  logic [63:0] cap_bits, cap_oe;
  int          rises;
  time         last_rise;
  int          period_bad, chg_bad, contention;
  logic [15:0] phy_resp;
  logic        rd_frame;
  logic        phy_en = 1'b0;
  logic        phy_val = 1'b1;
  logic        prev_o = 1'b0;

  always #5 clk = ~clk;

  mdio_cmd_master #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  always @(posedge mdc) begin
    cap_bits = {cap_bits[62:0], mdio_o};
    cap_oe   = {cap_oe[62:0], mdio_oe};
    if (phy_en && mdio_oe) contention++;
    if (rises > 0 && ($time - last_rise) != time'(2 * HALF * 10)) period_bad++;
    last_rise = $time;
    rises++;
  end

  always @(negedge mdc) begin
    if (rd_frame && rises == 47) begin
      phy_en = 1'b1; phy_val = 1'b0;
    end else if (rd_frame && rises >= 48 && rises <= 63) begin
      phy_en = 1'b1; phy_val = phy_resp[63 - rises];
    end else begin
      phy_en = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && mdc && (mdio_o !== prev_o)) chg_bad++;
    prev_o = mdio_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] dev, input logic [4:0] port,
                                     input logic [1:0] op, input logic [1:0] st,
                                     input logic [15:0] d);
    return {1'b1, 1'b0, dev, port, op, st, d};
  endfunction

  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    logic [1:0] ta = w[19] ? 2'b00 : 2'b10;
    return {32'hFFFF_FFFF, w[17:16], w[19:18], w[24:20], w[29:25], ta, w[15:0]};
  endfunction

  task automatic run_frame(input logic [31:0] w, input logic [15:0] resp,
                           input bit intrude, input logic [31:0] iw, output int dur);
    rises = 0; cap_bits = '0; cap_oe = '0; phy_resp = resp; rd_frame = w[19];
    period_bad = 0; chg_bad = 0; contention = 0;
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0;
    dur = 0;
    while (cmd_rdata[31] && dur < 20000) begin
      dur++;
      if (intrude && dur == 100) begin
        cmd_wr = 1'b1; cmd_wdata = iw;
      end else begin
        cmd_wr = 1'b0;
      end
      @(negedge clk);
    end
    cmd_wr = 1'b0;
  endtask

  task automatic check_frame(input logic [31:0] w, input logic [15:0] resp, input int dur);
    logic [63:0] ef = exp_frame(w);
    chk(dur == FRAME_CLKS, "R2 busy length", 64'(dur), 64'(FRAME_CLKS));
    chk(rises == 64, "R4 rising MDC count", 64'(rises), 64'd64);
    chk(period_bad == 0, "R3 MDC period", 64'(period_bad), 64'd0);
    chk(chg_bad == 0, "R9 MDIO changed while MDC high", 64'(chg_bad), 64'd0);
    chk(mdc == 1'b0, "R3 MDC low after frame", 64'(mdc), 64'd0);
    if (w[19]) begin
      chk(cap_bits[63:18] == ef[63:18], "R4 read header bits", 64'(cap_bits[63:18]), 64'(ef[63:18]));
      chk(cap_oe == {{46{1'b1}}, 18'b0}, "R6 output enable mask", cap_oe, {{46{1'b1}}, 18'b0});
      chk(contention == 0, "R6 no contention", 64'(contention), 64'd0);
      chk(cmd_rdata == {2'b00, w[29:16], resp}, "R6 read result", 64'(cmd_rdata), 64'({2'b00, w[29:16], resp}));
    end else begin
      chk(cap_bits == ef, "R5 driven frame bits", cap_bits, ef);
      chk(cap_oe == '1, "R5 output enable all bits", cap_oe, '1);
      chk(cmd_rdata == {2'b00, w[29:0]}, "R1 readback after write frame", 64'(cmd_rdata), 64'({2'b00, w[29:0]}));
    end
  endtask

  task automatic t_reset();
    chk(cmd_rdata == 32'h0, "R1 reset word", 64'(cmd_rdata), 64'h0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R3 idle pins", 64'({mdc, mdio_oe}), 64'h0);
  endtask

  task automatic t_idle_fields();
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = 32'h7ABC_1234;
    @(negedge clk); cmd_wr = 1'b0;
    repeat (4 * HALF) @(negedge clk);
    chk(cmd_rdata == 32'h3ABC_1234, "R1 fields stored, bit30 zero", 64'(cmd_rdata), 64'h3ABC_1234);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 no frame without access bit", 64'({mdc, mdio_oe}), 64'h0);
  endtask

  task automatic t_c22_write();
    int d;
    logic [31:0] w = mk(5'h11, 5'h05, 2'd1, 2'd1, 16'hBEEF);
    run_frame(w, 16'h0, 1'b0, 32'h0, d);
    check_frame(w, 16'h0, d);
    chk(cap_bits[31:28] == 4'b0101, "R4 clause22 start and write opcode", 64'(cap_bits[31:28]), 64'h5);
  endtask

  task automatic t_busy_ignore();
    int d;
    int r0;
    logic [31:0] w  = mk(5'h02, 5'h1F, 2'd1, 2'd1, 16'h0F0F);
    logic [31:0] iw = mk(5'h1D, 5'h03, 2'd2, 2'd0, 16'hAAAA);
    run_frame(w, 16'h0, 1'b1, iw, d);
    chk(cmd_rdata == {2'b00, w[29:0]}, "R8 fields unchanged by busy write", 64'(cmd_rdata), 64'({2'b00, w[29:0]}));
    chk(cap_bits == exp_frame(w), "R8 frame unchanged by busy write", cap_bits, exp_frame(w));
    chk(d == FRAME_CLKS, "R8 frame length unchanged", 64'(d), 64'(FRAME_CLKS));
    r0 = rises;
    repeat (6 * HALF) @(negedge clk);
    chk(rises == r0 && !cmd_rdata[31], "R8 no second frame", 64'(rises), 64'(r0));
  endtask

  task automatic t_c22_read(input logic [15:0] wdat);
    int d;
    logic [31:0] w = mk(5'h02, 5'h03, 2'd2, 2'd1, wdat);
    run_frame(w, 16'h1A2B, 1'b0, 32'h0, d);
    check_frame(w, 16'h1A2B, d);
    chk(cmd_rdata[15:0] == 16'h1A2B, "R7 read value independent of written data", 64'(cmd_rdata[15:0]), 64'h1A2B);
  endtask

  task automatic t_c45_addr_read();
    int d;
    logic [31:0] wa = mk(5'h03, 5'h07, 2'd0, 2'd0, 16'h0800);
    logic [31:0] wr = mk(5'h03, 5'h07, 2'd3, 2'd0, 16'h0000);
    run_frame(wa, 16'h0, 1'b0, 32'h0, d);
    check_frame(wa, 16'h0, d);
    chk(cap_bits[31:28] == 4'b0000, "R4 clause45 start and address opcode", 64'(cap_bits[31:28]), 64'h0);
    chk(cap_bits[22:18] == 5'h03 && cap_bits[15:0] == 16'h0800, "R10 address frame device and register",
        64'({cap_bits[22:18], cap_bits[15:0]}), 64'({5'h03, 16'h0800}));
    run_frame(wr, 16'hC0DE, 1'b0, 32'h0, d);
    check_frame(wr, 16'hC0DE, d);
    chk(cap_bits[22:18] == 5'h03, "R10 read frame device field", 64'(cap_bits[22:18]), 64'h03);
  endtask

  task automatic t_c45_write();
    int d;
    logic [31:0] w = mk(5'h1E, 5'h10, 2'd1, 2'd0, 16'h00FF);
    run_frame(w, 16'h0, 1'b0, 32'h0, d);
    check_frame(w, 16'h0, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rises = 0; last_rise = 0; rd_frame = 1'b0; phy_resp = '0;
    cap_bits = '0; cap_oe = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_fields();
    t_c22_write();
    t_busy_ignore();
    t_c22_read(16'h5555);
    t_c22_read(16'hFFFF);
    t_c45_addr_read();
    t_c45_write();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule